// File: doc/BRIEF.md
# Dual-Mode Video Packet Frame Delimiter

This block sits behind a receiver of isochronous video packets and turns the packet stream into a framed byte stream. Each input beat carries one byte together with first-of-packet and last-of-packet flags. A zero-length packet is carried as a single beat with the empty flag set, and its data is ignored. The output is a byte stream where every beat carries a two-bit tag. The tag tells payload bytes, injected header bytes and the two zero-data marker beats that close one frame and open the next.

The boundary rule depends on a static mode input. In raw 4:2:2 mode, an empty packet arms a pending flag. The next non-empty packet is then preceded by a frame-end marker and a frame-start marker, and no header is inserted. In compressed mode, empty packets are dropped silently. A packet that begins with the start-of-image pair 0xFF 0xD8 is a boundary instead. The pair is removed, and a replacement header read from a small programmable memory follows the frame-start marker. Both ports use valid/ready. A beat moves on a rising edge where valid and ready are both high. The source must hold a beat stable until it is taken. `in_ready` may depend combinationally on `out_ready`. Every beat the block generates itself (markers, header bytes, a released 0xFF) stays on the output until it is accepted.

Top module: `vid_frame_delim`

## Requirements
- R1: In raw mode (`mode_cmp`=0), the bytes of non-empty packets leave in arrival order and unchanged, with tag 0 (payload).
- R2: In raw mode, an empty packet arms a pending flag and produces no output. The next non-empty packet is preceded by a tag 2 beat (frame end) and then a tag 3 beat (frame start), both with data 0x00 and with no tag 1 bytes. Several empty packets in a row give a single boundary, and the packet after the boundary gets none.
- R3: A `cap_start` pulse clears the pending flag. When it coincides with an accepted empty beat, the clear wins, so the next packet opens with no boundary.
- R4: In compressed mode (`mode_cmp`=1), a packet of two or more bytes whose first byte is 0xFF and second byte is 0xD8 produces tag 2, then tag 3, then `hdr_len` tag 1 bytes taken from header addresses 0 up to `hdr_len`-1, then the packet's remaining bytes as tag 0. The 0xFF and 0xD8 bytes never appear.
- R5: In compressed mode, a packet that does not start with that pair is forwarded whole as tag 0. This includes a one-byte 0xFF packet, 0xFF followed by another value, and a pair found later than the start of a packet.
- R6: In compressed mode, empty packets produce no output beat and start no frame.
- R7: With `hdr_len` = 0, a compressed-mode boundary emits the frame-start beat followed directly by the packet's remaining payload.
- R8: While `out_ready` is low, a presented output beat stays valid with unchanged data and tag. No beat is lost or repeated.
- R9: After reset, `out_valid` is low and the pending flag is clear.
- R10: A frame-end beat is always followed by a frame-start beat on the next output beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_cmp | input | 1 | 1 = compressed mode, 0 = raw mode; change only while idle |
| cap_start | input | 1 | Capture-start pulse; clears the pending flag |
| hdr_len | input | $clog2(HDR_DEPTH+1) | Number of header bytes to inject, at most HDR_DEPTH |
| hdr_we | input | 1 | Header memory write enable |
| hdr_waddr | input | $clog2(HDR_DEPTH) | Header memory write address |
| hdr_wdata | input | 8 | Header memory write data |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted this cycle when high with in_valid |
| in_data | input | 8 | Input byte |
| in_first | input | 1 | Beat is the first byte of its packet |
| in_last | input | 1 | Beat is the last byte of its packet |
| in_empty | input | 1 | Beat stands for a zero-length packet; data ignored |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_data | output | 8 | Output byte (0x00 on marker beats) |
| out_tag | output | 2 | 0 payload, 1 header, 2 frame end, 3 frame start |

## Verification
The bench builds the block with HDR_DEPTH = 8. At that size a header of the full memory depth (eight bytes, hitting the top address and the end-of-count compare) costs only a few cycles, and so do a three-byte header and a zero-length header. A second pass repeats raw and compressed traffic with pseudo-random downstream stalls. That pass lands stalls on markers, on header bytes and on the released 0xFF of a near-miss packet.

// File: rtl/vfd_pkg.sv
package vfd_pkg;

  localparam logic [1:0] TAG_PAY   = 2'd0;
  localparam logic [1:0] TAG_HDR   = 2'd1;
  localparam logic [1:0] TAG_END   = 2'd2;
  localparam logic [1:0] TAG_START = 2'd3;

  localparam logic [7:0] SOI_HI = 8'hFF;
  localparam logic [7:0] SOI_LO = 8'hD8;

  typedef enum logic [2:0] {
    ST_PASS,
    ST_SECOND,
    ST_END,
    ST_START,
    ST_HDR
  } vfd_state_e;

endpackage

// File: rtl/vfd_hdr_mem.sv
module vfd_hdr_mem #(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];

endmodule

// File: rtl/vfd_soi_match.sv
module vfd_soi_match #(
  parameter logic [7:0] HI = 8'hFF,
  parameter logic [7:0] LO = 8'hD8
) (
  input  logic [7:0] data,
  input  logic       empty,
  output logic       is_hi,
  output logic       is_lo
);

  assign is_hi = !empty && (data == HI);
  assign is_lo = !empty && (data == LO);

endmodule

// File: rtl/vfd_ctrl.sv
module vfd_ctrl
  import vfd_pkg::*;
#(
  parameter int HDR_DEPTH = 32,
  localparam int AW = $clog2(HDR_DEPTH),
  localparam int LW = $clog2(HDR_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_cmp,
  input  logic          cap_start,
  input  logic [LW-1:0] hdr_len,
  input  logic          in_valid,
  input  logic          in_first,
  input  logic          in_last,
  input  logic          in_empty,
  input  logic          in_hi,
  input  logic          in_lo,
  input  logic          out_ready,
  output logic          in_ready,
  output logic          out_valid,
  output logic [1:0]    out_tag,
  output logic          emit_held,
  output logic [AW-1:0] hdr_idx
);

  vfd_state_e state_q, state_d;
  logic          pend_q, pend_d;
  logic          use_hdr_q, use_hdr_d;
  logic [AW-1:0] idx_q, idx_d;
  logic          hdr_done;

  assign hdr_done = (LW'(idx_q) + LW'(1)) == hdr_len;
  assign hdr_idx  = idx_q;

  always_comb begin
    state_d   = state_q;
    pend_d    = pend_q;
    use_hdr_d = use_hdr_q;
    idx_d     = idx_q;
    in_ready  = 1'b0;
    out_valid = 1'b0;
    out_tag   = TAG_PAY;
    emit_held = 1'b0;
    unique case (state_q)
      ST_PASS: begin
        if (in_valid) begin
          if (in_empty) begin
            in_ready = 1'b1;
            if (!mode_cmp) pend_d = 1'b1;
          end else if (!mode_cmp && in_first && pend_q) begin
            pend_d    = 1'b0;
            use_hdr_d = 1'b0;
            state_d   = ST_END;
          end else if (mode_cmp && in_first && in_hi && !in_last) begin
            in_ready = 1'b1;
            state_d  = ST_SECOND;
          end else begin
            out_valid = 1'b1;
            in_ready  = out_ready;
          end
        end
      end
      ST_SECOND: begin
        if (in_valid) begin
          if (in_lo) begin
            in_ready  = 1'b1;
            use_hdr_d = 1'b1;
            state_d   = ST_END;
          end else begin
            out_valid = 1'b1;
            emit_held = 1'b1;
            if (out_ready) state_d = ST_PASS;
          end
        end
      end
      ST_END: begin
        out_valid = 1'b1;
        out_tag   = TAG_END;
        if (out_ready) state_d = ST_START;
      end
      ST_START: begin
        out_valid = 1'b1;
        out_tag   = TAG_START;
        if (out_ready) begin
          idx_d   = '0;
          state_d = (use_hdr_q && hdr_len != '0) ? ST_HDR : ST_PASS;
        end
      end
      ST_HDR: begin
        out_valid = 1'b1;
        out_tag   = TAG_HDR;
        if (out_ready) begin
          if (hdr_done) state_d = ST_PASS;
          else          idx_d   = idx_q + AW'(1);
        end
      end
      default: state_d = ST_PASS;
    endcase
    if (cap_start) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_PASS;
      pend_q    <= 1'b0;
      use_hdr_q <= 1'b0;
      idx_q     <= '0;
    end else begin
      state_q   <= state_d;
      pend_q    <= pend_d;
      use_hdr_q <= use_hdr_d;
      idx_q     <= idx_d;
    end
  end

endmodule

// File: rtl/vid_frame_delim.sv
module vid_frame_delim
  import vfd_pkg::*;
#(
  parameter int HDR_DEPTH = 32,
  localparam int AW = $clog2(HDR_DEPTH),
  localparam int LW = $clog2(HDR_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_cmp,
  input  logic          cap_start,
  input  logic [LW-1:0] hdr_len,
  input  logic          hdr_we,
  input  logic [AW-1:0] hdr_waddr,
  input  logic [7:0]    hdr_wdata,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  input  logic          in_first,
  input  logic          in_last,
  input  logic          in_empty,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_data,
  output logic [1:0]    out_tag
);

  logic          in_hi, in_lo;
  logic          emit_held;
  logic [AW-1:0] hdr_idx;
  logic [7:0]    hdr_byte;

  vfd_soi_match #(.HI(SOI_HI), .LO(SOI_LO)) u_match (
    .data  (in_data),
    .empty (in_empty),
    .is_hi (in_hi),
    .is_lo (in_lo)
  );

  vfd_hdr_mem #(.DEPTH(HDR_DEPTH)) u_mem (
    .clk   (clk),
    .we    (hdr_we),
    .waddr (hdr_waddr),
    .wdata (hdr_wdata),
    .raddr (hdr_idx),
    .rdata (hdr_byte)
  );

  vfd_ctrl #(.HDR_DEPTH(HDR_DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_cmp  (mode_cmp),
    .cap_start (cap_start),
    .hdr_len   (hdr_len),
    .in_valid  (in_valid),
    .in_first  (in_first),
    .in_last   (in_last),
    .in_empty  (in_empty),
    .in_hi     (in_hi),
    .in_lo     (in_lo),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_tag   (out_tag),
    .emit_held (emit_held),
    .hdr_idx   (hdr_idx)
  );

  always_comb begin
    unique case (out_tag)
      TAG_PAY: out_data = emit_held ? SOI_HI : in_data;
      TAG_HDR: out_data = hdr_byte;
      default: out_data = 8'h00;
    endcase
  end

endmodule

// File: rtl/vfd_checker.sv
module vfd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_cmp,
  input logic       in_valid,
  input logic       in_ready,
  input logic       in_empty,
  input logic       out_valid,
  input logic       out_ready,
  input logic [1:0] out_tag
);

  AST_END_BEFORE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_tag == vfd_pkg::TAG_END)
    |=> (out_valid && out_tag == vfd_pkg::TAG_START)); // R10

  AST_MARKER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && out_tag[1])
    |=> (out_valid && $stable(out_tag))); // R8

  AST_CMP_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cmp && in_valid && in_empty && in_ready) |-> !out_valid); // R6

  AST_RAW_NO_HDR: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_cmp |-> !(out_valid && out_tag == vfd_pkg::TAG_HDR)); // R2

endmodule

bind vid_frame_delim vfd_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_cmp  (mode_cmp),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_empty  (in_empty),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_tag   (out_tag)
);

// File: tb/vid_frame_delim_bench.sv
module vid_frame_delim_bench;

  localparam int DEPTH = 8;
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_cmp = 1'b0;
  logic          cap_start = 1'b0;
  logic [LW-1:0] hdr_len = '0;
  logic          hdr_we = 1'b0;
  logic [AW-1:0] hdr_waddr = '0;
  logic [7:0]    hdr_wdata = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [7:0]    in_data = '0;
  logic          in_first = 1'b0;
  logic          in_last = 1'b0;
  logic          in_empty = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [7:0]    out_data;
  logic [1:0]    out_tag;

  vid_frame_delim #(.HDR_DEPTH(DEPTH)) u_vid_frame_delim (.*);

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // reference model state
  int    exp_d[$];
  int    exp_t[$];
  string exp_r[$];
  bit    m_pend = 0;
  logic [7:0] m_hdr [DEPTH];
  logic [7:0] pkt[$];

  bit        bp_en = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic push_exp(input int d, input int t, input string r);
    exp_d.push_back(d); exp_t.push_back(t); exp_r.push_back(r);
  endtask

  task automatic check(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // downstream ready pattern
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = bp_en ? (lfsr[0] | lfsr[3]) : 1'b1;
  end

  // output monitor, compared on every clock
  bit         stall_prev = 0;
  logic [7:0] prev_d;
  logic [1:0] prev_t;
  always @(negedge clk) begin
    if (!rst_n) begin
      check(out_valid == 1'b0, "R9", out_valid, 0);
      stall_prev = 0;
    end else begin
      if (stall_prev) begin
        check(out_valid && out_data == prev_d && out_tag == prev_t, "R8",
              {out_valid, out_tag, out_data}, {1'b1, prev_t, prev_d});
      end
      stall_prev = out_valid && !out_ready;
      prev_d = out_data;
      prev_t = out_tag;
      if (out_valid && out_ready) begin
        if (exp_d.size() == 0) begin
          check(1'b0, "R8", {out_tag, out_data}, 0);
        end else begin
          automatic int    ed = exp_d.pop_front();
          automatic int    et = exp_t.pop_front();
          automatic string er = exp_r.pop_front();
          check(out_data == ed[7:0] && out_tag == et[1:0], er,
                {out_tag, out_data}, {et[1:0], ed[7:0]});
        end
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired R8 actual=%0d expected=%0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic send_beat(input logic [7:0] d, input bit f, input bit l,
                           input bit e, input bit clr);
    in_valid = 1'b1; in_data = d; in_first = f; in_last = l; in_empty = e;
    cap_start = clr;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk); #1;
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0; in_empty = 1'b0;
    cap_start = 1'b0;
  endtask

  // empty packet; clr=1 raises cap_start in the same cycle
  task automatic send_empty(input bit clr, input string r);
    if (clr) m_pend = 0;
    else if (!mode_cmp) m_pend = 1;
    send_beat(8'h00, 1'b0, 1'b0, 1'b1, clr);
  endtask

  // non-empty packet held in pkt; model computes expected beats first
  task automatic send_pkt(input string r);
    automatic int n = pkt.size();
    automatic int s = 0;
    if (!mode_cmp) begin
      if (m_pend) begin
        push_exp(0, 2, "R2"); push_exp(0, 3, "R2");
        m_pend = 0;
      end
    end else if (n >= 2 && pkt[0] == 8'hFF && pkt[1] == 8'hD8) begin
      push_exp(0, 2, "R4"); push_exp(0, 3, "R4");
      for (int i = 0; i < int'(hdr_len); i++) push_exp(m_hdr[i], 1, "R4");
      s = 2;
    end
    for (int i = s; i < n; i++) push_exp(pkt[i], 0, r);
    for (int i = 0; i < n; i++) send_beat(pkt[i], i == 0, i == n - 1, 1'b0, 1'b0);
  endtask

  task automatic drain(input string r);
    for (int i = 0; i < 200 && exp_d.size() != 0; i++) @(posedge clk);
    #1;
    check(exp_d.size() == 0, r, exp_d.size(), 0);
  endtask

  task automatic cap_pulse;
    @(posedge clk); #1; cap_start = 1'b1; m_pend = 0;
    @(posedge clk); #1; cap_start = 1'b0;
  endtask

  task automatic raw_round;
    pkt = '{8'h11, 8'h22, 8'h33}; send_pkt("R1");
    send_empty(0, "R2");
    pkt = '{8'h44, 8'h55}; send_pkt("R1");
    send_empty(0, "R2"); send_empty(0, "R2");
    pkt = '{8'h66}; send_pkt("R2");
    pkt = '{8'h77, 8'h78}; send_pkt("R2");
    send_empty(0, "R3"); cap_pulse();
    pkt = '{8'h80, 8'h81}; send_pkt("R3");
    send_empty(1, "R3");
    pkt = '{8'h82}; send_pkt("R3");
    drain("R2");
  endtask

  task automatic cmp_round;
    hdr_len = LW'(3);
    pkt = '{8'hFF, 8'hD8, 8'h01, 8'h02}; send_pkt("R4");
    send_empty(0, "R6");
    pkt = '{8'h05, 8'h06}; send_pkt("R6");
    send_empty(0, "R6"); send_empty(0, "R6");
    pkt = '{8'h07}; send_pkt("R6");
    pkt = '{8'hFF}; send_pkt("R5");
    pkt = '{8'hFF, 8'h12, 8'h13}; send_pkt("R5");
    pkt = '{8'h10, 8'hFF, 8'hD8}; send_pkt("R5");
    pkt = '{8'hFF, 8'hFF, 8'hD8}; send_pkt("R5");
    hdr_len = '0;
    pkt = '{8'hFF, 8'hD8, 8'h31}; send_pkt("R7");
    pkt = '{8'hFF, 8'hD8}; send_pkt("R7");
    drain("R7");
    hdr_len = LW'(DEPTH);
    pkt = '{8'hFF, 8'hD8, 8'h77}; send_pkt("R4");
    drain("R4");
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) m_hdr[i] = 8'hA0 + 8'(i);
    repeat (3) @(posedge clk);
    #1; rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R9", out_valid, 0);
    @(posedge clk); #1;
    for (int i = 0; i < DEPTH; i++) begin
      hdr_we = 1'b1; hdr_waddr = AW'(i); hdr_wdata = m_hdr[i];
      @(posedge clk); #1;
    end
    hdr_we = 1'b0;
    // pending flag clear after reset: first packet has no boundary (R9)
    pkt = '{8'h01}; send_pkt("R9");
    drain("R9");
    raw_round();
    mode_cmp = 1'b1;
    cmp_round();
    // second pass with downstream stalls
    bp_en = 1;
    mode_cmp = 1'b0; cap_pulse();
    raw_round();
    mode_cmp = 1'b1;
    cmp_round();
    bp_en = 0;
    repeat (4) @(posedge clk);
    #1;
    check(exp_d.size() == 0 && !out_valid, "R8", exp_d.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule